// File: doc/BRIEF.md
# Free-Running Time-of-Year Tag Keeper

This block holds a single time-of-year tag that every receive and transmit channel of a bus interface reads, so timestamps taken on different channels agree with each other. The tag is split into day of year, hour, minute, second and microsecond fields. It advances on a local one-microsecond enable and is presented as two 32-bit words.

An upstream time-code decoder hands the block decoded frames. Each frame is a one-cycle valid strobe with day, hour, minute and second, plus a separate on-time strobe that marks the instant the last frame's time becomes true. The block decides without software help whether to follow that reference or to run on its local count. Two valid frames exactly one second apart make it lock. More than the loss window of local ticks without a frame makes it fall back to free running, and the count carries on from where it was. While locked, each frame is armed and copied into the tag at the next on-time strobe, with the microseconds cleared.

Top module: `time_tag_keeper`

## Requirements
- R1: A synchronous reset sets the tag to day 1, 00:00:00.000000 (low word 0, high word 0x0000_0800), clears `synced` and holds `mode_chg` low.
- R2: Each cycle with `tick_us` high adds one to the microsecond field. From US_PER_SEC-1 it returns to 0 and carries one second. Without a tick or a load the tag holds.
- R3: Seconds and minutes wrap from 59 to 0, hours from 23 to 0, and the day runs from 1 to DAYS_PER_YEAR and then back to 1. Each wrap carries into the next field up.
- R4: The low word holds microseconds in bits [19:0] and seconds in [25:20], with [31:26] zero. The high word holds minutes in [5:0], hours in [10:6] and day in [19:11], with [31:20] zero.
- R5: When out of lock, a valid frame whose time is exactly one second after the previous valid frame sets `synced` on the edge that takes it in.
- R6: A frame whose time does not follow the previous one by one second does not give lock. A frame with a field out of range (hour over 23, minute or second over 59, day 0 or over DAYS_PER_YEAR) is ignored entirely.
- R7: While locked, an `on_time` strobe after a frame loads that frame's day, hour, minute and second and sets microseconds to 0. A tick in the same cycle loses to the load. The tag does not change before the strobe.
- R8: When LOSS_TICKS+1 ticks pass with no valid frame, `synced` clears on that tick's edge and the tag keeps counting without a jump. After LOSS_TICKS ticks it is still set.
- R9: Out of lock, `on_time` strobes and lone frames leave the tag untouched. Any armed frame is dropped when lock is lost.
- R10: `mode_chg` is high for exactly the one cycle in which `synced` has just changed, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_us | input | 1 | One-microsecond enable |
| frm_valid | input | 1 | Decoded frame strobe |
| frm_day | input | 9 | Frame day of year |
| frm_hour | input | 5 | Frame hour |
| frm_min | input | 6 | Frame minute |
| frm_sec | input | 6 | Frame second |
| on_time | input | 1 | Strobe marking the instant the armed frame time is true |
| tag_lo | output | 32 | Seconds and microseconds word |
| tag_hi | output | 32 | Day, hour and minute word |
| synced | output | 1 | 1 while following the reference, 0 while free running |
| mode_chg | output | 1 | One-cycle pulse on each change of `synced` |

## Verification
The bench runs a small configuration (ten ticks per second, a 25-tick loss window) with a full tick-by-tick sweep over several seconds, so every microsecond value and its carry are checked against an arithmetic model. Frames are chosen to land on each wrap boundary: second into minute, minute into hour, and the last day of the year into day 1. This separates faults in each carry stage. Frame pairs with a skipped second, out-of-range frames and lone frames show that lock needs exactly a one-second step. A run of ticks one short of the window and then one past it pins down where lock is lost, and a tick arriving together with the on-time strobe shows that the load wins.

// File: rtl/time_tag_keeper.sv
module time_tag_keeper #(
  parameter int US_PER_SEC    = 1000000,
  parameter int LOSS_TICKS    = 2000000,
  parameter int DAYS_PER_YEAR = 366
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_us,
  input  logic        frm_valid,
  input  logic [8:0]  frm_day,
  input  logic [4:0]  frm_hour,
  input  logic [5:0]  frm_min,
  input  logic [5:0]  frm_sec,
  input  logic        on_time,
  output logic [31:0] tag_lo,
  output logic [31:0] tag_hi,
  output logic        synced,
  output logic        mode_chg
);
  localparam int UW = 20;
  localparam int CW = $clog2(LOSS_TICKS + 1);
  localparam logic [UW-1:0] US_LAST = UW'(US_PER_SEC - 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(LOSS_TICKS);
  localparam logic [8:0]    DAY_MAX = 9'(DAYS_PER_YEAR);

  function automatic logic [25:0] sec_after(input logic [25:0] t);
    logic [8:0] d; logic [4:0] h; logic [5:0] m, s;
    {d, h, m, s} = t;
    if (s == 6'd59) begin
      s = 6'd0;
      if (m == 6'd59) begin
        m = 6'd0;
        if (h == 5'd23) begin
          h = 5'd0;
          d = (d == DAY_MAX) ? 9'd1 : d + 9'd1;
        end else h = h + 5'd1;
      end else m = m + 6'd1;
    end else s = s + 6'd1;
    return {d, h, m, s};
  endfunction

  logic [UW-1:0] us_q;
  logic [25:0]   now_q;
  logic [25:0]   prev_q, pend_q;
  logic          prev_ok, pend_ok, sync_q, chg_q;
  logic [CW-1:0] to_cnt;

  logic [25:0] frm_t;
  logic        frm_ok, good_pair, acquire, lose, load, us_wrap;

  assign frm_t     = {frm_day, frm_hour, frm_min, frm_sec};
  assign frm_ok    = frm_valid && frm_hour < 5'd24 && frm_min < 6'd60 && frm_sec < 6'd60 &&
                     frm_day != 9'd0 && frm_day <= DAY_MAX;
  assign good_pair = frm_ok && prev_ok && (frm_t == sec_after(prev_q));
  assign acquire   = good_pair && !sync_q;
  assign lose      = tick_us && !frm_ok && (to_cnt == CNT_MAX);
  assign load      = on_time && pend_ok && sync_q;
  assign us_wrap   = tick_us && (us_q == US_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      us_q  <= '0;
      now_q <= {9'd1, 17'd0};
    end else if (load) begin
      us_q  <= '0;
      now_q <= pend_q;
    end else if (us_wrap) begin
      us_q  <= '0;
      now_q <= sec_after(now_q);
    end else if (tick_us) begin
      us_q  <= us_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      to_cnt  <= '0;
      prev_ok <= 1'b0;
      prev_q  <= '0;
    end else if (frm_ok) begin
      to_cnt  <= '0;
      prev_ok <= 1'b1;
      prev_q  <= frm_t;
    end else if (tick_us) begin
      if (lose) prev_ok <= 1'b0;
      else      to_cnt  <= to_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_ok <= 1'b0;
      pend_q  <= '0;
    end else if (lose) begin
      pend_ok <= 1'b0;
    end else if (frm_ok && (sync_q || acquire)) begin
      pend_ok <= 1'b1;
      pend_q  <= frm_t;
    end else if (load) begin
      pend_ok <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      chg_q <= acquire || (lose && sync_q);
      if (acquire)   sync_q <= 1'b1;
      else if (lose) sync_q <= 1'b0;
    end
  end

  assign tag_lo   = {6'd0, now_q[5:0], us_q};
  assign tag_hi   = {12'd0, now_q[25:17], now_q[16:12], now_q[11:6]};
  assign synced   = sync_q;
  assign mode_chg = chg_q;

  AST_US_RANGE: assert property (@(posedge clk) disable iff (rst)
    us_q <= US_LAST);  // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!tick_us && !on_time) |=> $stable(tag_lo) && $stable(tag_hi));  // R2
  AST_FIELD_RANGE: assert property (@(posedge clk) disable iff (rst)
    tag_lo[25:20] < 6'd60 && tag_hi[5:0] < 6'd60 && tag_hi[10:6] < 5'd24 &&
    tag_hi[19:11] != 9'd0 && tag_hi[19:11] <= DAY_MAX);  // R3
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    tag_lo[31:26] == 6'd0 && tag_hi[31:20] == 12'd0);  // R4
  AST_LOCK_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
    !synced && frm_valid == 1'b0 |=> !synced);  // R5
  AST_UNLOCK_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    synced && !tick_us |=> synced);  // R8
  AST_FREE_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!synced && !tick_us) |=> $stable(tag_lo) && $stable(tag_hi));  // R9
  AST_CHG_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> !mode_chg);  // R10
endmodule

// File: tb/time_tag_keeper_bench.sv
module time_tag_keeper_bench;
  localparam int CLK_PERIOD = 10;
  localparam int US   = 10;
  localparam int LOSS = 25;
  localparam int DAYS = 366;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_us = 1'b0, frm_valid = 1'b0, on_time = 1'b0;
  logic [8:0] frm_day = '0;
  logic [4:0] frm_hour = '0;
  logic [5:0] frm_min = '0, frm_sec = '0;
  logic [31:0] tag_lo, tag_hi;
  logic synced, mode_chg;

  int checks = 0, failures = 0, cycles = 0;
  int ed, eh, em, es, eu;

  always #(CLK_PERIOD/2) clk = ~clk;

  time_tag_keeper #(.US_PER_SEC(US), .LOSS_TICKS(LOSS), .DAYS_PER_YEAR(DAYS)) u_time_tag_keeper (
    .clk(clk), .rst(rst), .tick_us(tick_us), .frm_valid(frm_valid),
    .frm_day(frm_day), .frm_hour(frm_hour), .frm_min(frm_min), .frm_sec(frm_sec),
    .on_time(on_time), .tag_lo(tag_lo), .tag_hi(tag_hi), .synced(synced), .mode_chg(mode_chg));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_tag(input string req);
    chk(req, {tag_hi, tag_lo},
        {32'(ed) << 11 | 32'(eh) << 6 | 32'(em), 32'(es) << 20 | 32'(eu)});
  endtask

  task automatic m_second();
    int t;
    t = ((ed - 1) * 86400 + eh * 3600 + em * 60 + es + 1) % (DAYS * 86400);
    ed = t / 86400 + 1; t = t % 86400;
    eh = t / 3600; t = t % 3600;
    em = t / 60; es = t % 60;
  endtask

  task automatic m_tick();
    if (eu == US - 1) begin eu = 0; m_second(); end
    else eu++;
  endtask

  task automatic cyc(input logic t, input logic f, input logic o);
    tick_us = t; frm_valid = f; on_time = o;
    @(negedge clk);
    tick_us = 1'b0; frm_valid = 1'b0; on_time = 1'b0;
    cycles++;
  endtask

  task automatic frame(input int d, input int h, input int m, input int s);
    frm_day = 9'(d); frm_hour = 5'(h); frm_min = 6'(m); frm_sec = 6'(s);
    cyc(1'b0, 1'b1, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin cyc(1'b1, 1'b0, 1'b0); m_tick(); end
  endtask

  task automatic set_model(input int d, input int h, input int m, input int s);
    ed = d; eh = h; em = m; es = s; eu = 0;
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    set_model(1, 0, 0, 0);
    chk("R1 reset lo", tag_lo, 0);
    chk("R1 reset hi R4", tag_hi, 32'h800);
    chk("R1 reset synced", synced, 0);
    chk("R1 reset mode_chg", mode_chg, 0);

    for (int i = 0; i < 3 * US + 3; i++) begin
      ticks(1);
      chk_tag("R2 tick sweep");
    end
    cyc(1'b0, 1'b0, 1'b0); cyc(1'b0, 1'b0, 1'b0);
    chk_tag("R2 hold without tick");
    chk("R4 seconds field", tag_lo[25:20], 6'd3);

    frame(10, 5, 6, 7);
    frame(10, 5, 6, 9);
    chk("R6 skipped second no lock", synced, 0);
    frame(10, 24, 6, 10);
    chk("R6 bad hour ignored", synced, 0);
    frame(0, 5, 6, 10);
    chk("R6 day zero ignored", synced, 0);
    cyc(1'b0, 1'b0, 1'b1);
    chk_tag("R9 free on_time no load");

    frame(366, 23, 59, 58);
    chk("R6 non-consecutive no lock", synced, 0);
    frame(366, 23, 59, 59);
    chk("R5 lock on consecutive pair", synced, 1);
    chk("R10 pulse on lock", mode_chg, 1);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R10 pulse one cycle", mode_chg, 0);
    chk_tag("R7 no change before strobe");
    cyc(1'b0, 1'b0, 1'b1);
    set_model(366, 23, 59, 59);
    chk_tag("R7 load at strobe");
    ticks(US);
    chk_tag("R3 year wrap to day 1");
    chk("R3 day field", tag_hi[19:11], 9'd1);

    frame(5, 10, 59, 59);
    ticks(3);
    cyc(1'b1, 1'b0, 1'b1);
    set_model(5, 10, 59, 59);
    chk_tag("R7 load beats tick");
    ticks(US);
    chk_tag("R3 hour carry");
    frame(9, 12, 34, 59);
    cyc(1'b0, 1'b0, 1'b1);
    set_model(9, 12, 34, 59);
    ticks(US);
    chk_tag("R3 minute carry");
    chk("R4 minute field", tag_hi[5:0], 6'd35);

    frame(100, 0, 0, 0);
    cyc(1'b0, 1'b0, 1'b1);
    set_model(100, 0, 0, 0);
    ticks(LOSS);
    chk("R8 still locked at window", synced, 1);
    chk("R10 no pulse while locked", mode_chg, 0);
    ticks(1);
    chk("R8 lock lost", synced, 0);
    chk("R10 pulse on loss", mode_chg, 1);
    chk_tag("R8 counting continues");
    ticks(7);
    chk_tag("R8 free running count");
    chk("R10 pulse cleared", mode_chg, 0);

    frame(200, 1, 2, 3);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R9 lone frame no lock", synced, 0);
    chk_tag("R9 lone frame no load");
    frame(200, 1, 2, 4);
    chk("R5 relock", synced, 1);
    chk("R10 pulse on relock", mode_chg, 1);
    cyc(1'b0, 1'b0, 1'b1);
    set_model(200, 1, 2, 4);
    chk_tag("R7 load after relock");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule